// File: doc/BRIEF.md
# Two-Wire Bus Timing Compliance Monitor

This block watches the clock line (SCL) and data line (SDA) of an I2C bus without ever driving them. It samples both lines with a fast system clock. From those samples it finds start, repeated-start and stop conditions and tracks whether a transfer is in progress. It measures every SCL high and low phase in system-clock cycles, and also measures the setup time before a repeated start, the setup time before a stop, and the idle gap between a stop and the next start.

Each measurement is compared with a minimum cycle count. There are two sets of minimums, one for standard mode (100 kHz) and one for fast mode (400 kHz), and a one-bit mode input selects which set applies. All minimums are parameters. By default they are derived from the system clock frequency.

A violated rule produces a one-cycle pulse on that rule's own output bit and sets a matching sticky bit. The sticky bits stay set until a synchronous clear. All outputs are plain status pins, with no handshake. The block never stalls and never pushes back on the bus, so there is no back-pressure.

Top module: `i2c_timing_monitor`

## Requirements
- R1: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. `bus_busy` goes high two clock cycles after the start reaches the inputs and goes low two cycles after the stop reaches the inputs.
- R2: While the bus is busy, an SCL high phase shorter than the high minimum raises rule bit 0 when SCL falls.
- R3: While the bus is busy, an SCL low phase shorter than the low minimum raises rule bit 1 when SCL rises.
- R4: A start seen while the bus is busy is a repeated start. If SCL has been high for fewer cycles than the repeated-start setup minimum when SDA falls, rule bit 2 is raised.
- R5: If SCL has been high for fewer cycles than the stop setup minimum when a stop is seen, rule bit 3 is raised.
- R6: A start seen while the bus is idle raises rule bit 4 if fewer cycles than the bus-free minimum have passed since the last stop. A start seen while busy never raises bit 4.
- R7: `fast_mode` = 0 selects the standard set: high 4.0 us, low 4.7 us, repeated-start setup 4.7 us, stop setup 4.0 us, bus free 4.7 us. `fast_mode` = 1 selects the fast set: 0.6, 1.3, 0.6, 0.6 and 1.3 us. At 50 MHz these are 200/235/235/200/235 and 30/65/30/30/65 cycles.
- R8: Each violation raises `viol_pulse` for exactly one cycle, two cycles after the offending line change reaches the inputs.
- R9: A pulsed rule bit also sets the same bit in `viol_sticky`. Sticky bits only accumulate until `clear_sticky` is high at a clock edge, which zeroes them; a violation in that same cycle still sets its bit.
- R10: SCL phases are not checked while the bus is idle. SCL toggling with no start raises neither bit 0 nor bit 1.
- R11: While `rst_n` is low, and after it is released, `bus_busy`, `viol_pulse` and `viol_sticky` are all zero. The timers start as if the lines had been idle for the longest measurable time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Observed SCL line level |
| sda_in | input | 1 | Observed SDA line level |
| fast_mode | input | 1 | 0 selects standard-mode minimums, 1 selects fast-mode minimums |
| clear_sticky | input | 1 | Synchronous clear of the sticky violation bits |
| viol_pulse | output | 5 | One-cycle violation pulses (bit 0 high, 1 low, 2 repeated-start setup, 3 stop setup, 4 bus free) |
| viol_sticky | output | 5 | Sticky violation bits, same layout as `viol_pulse` |
| bus_busy | output | 1 | High between a start and the following stop |

## Verification
Every result of this block is due two clock edges after a line change is applied: one edge for the input sampling register and one edge for the output register. The condition detect and the comparison against the minimum both take place between those two edges. The bench drives on falling clock edges and tracks time in whole cycles. It has one directed case that samples a stop-setup pulse exactly one, two and three falling edges after the SDA rise, and `bus_busy` one and two edges after a start. In the random transactions, the bench counts pulses per rule on every falling edge. It compares those counts with a model built from the phase lengths it chose, once the bus has settled at least three cycles after each stop.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int NUM_RULES = 5;

  // Bit positions inside viol_pulse / viol_sticky
  typedef enum int unsigned {
    RULE_HIGH      = 0,
    RULE_LOW       = 1,
    RULE_SU_RSTART = 2,
    RULE_SU_STOP   = 3,
    RULE_BUS_FREE  = 4
  } rule_e;

  // Nanoseconds to whole system-clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/i2c_mon_sampler.sv
module i2c_mon_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c,
  output logic busy
);

  logic scl_s, sda_s, scl_d, sda_d;

  // One register stage on each line, then a delayed copy for edge finding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= scl_in;
      sda_s <= sda_in;
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & sda_d & ~sda_s;
  assign stop_c   = scl_s & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= (busy | start_c) & ~stop_c;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> busy); // R1
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !busy); // R1

endmodule

// File: rtl/i2c_mon_timer.sv
module i2c_mon_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] SAT = '1;

  // count = cycles elapsed since the last restart, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= SAT;
    else if (restart)        count <= {{(CNT_W-1){1'b0}}, 1'b1};
    else if (count != SAT)   count <= count + 1'b1;
  end

endmodule

// File: rtl/i2c_mon_rules.sv
module i2c_mon_rules
  import i2c_mon_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STD_HIGH    = 200,
  parameter int STD_LOW     = 235,
  parameter int STD_SU_RS   = 235,
  parameter int STD_SU_STOP = 200,
  parameter int STD_BUF     = 235,
  parameter int FST_HIGH    = 30,
  parameter int FST_LOW     = 65,
  parameter int FST_SU_RS   = 30,
  parameter int FST_SU_STOP = 30,
  parameter int FST_BUF     = 65
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fast_mode,
  input  logic                 clear_sticky,
  input  logic [CNT_W-1:0]     scl_cnt,
  input  logic [CNT_W-1:0]     free_cnt,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_c,
  input  logic                 stop_c,
  input  logic                 busy,
  output logic [NUM_RULES-1:0] viol_pulse,
  output logic [NUM_RULES-1:0] viol_sticky
);

  localparam int STD_MIN [NUM_RULES] = '{STD_HIGH, STD_LOW, STD_SU_RS, STD_SU_STOP, STD_BUF};
  localparam int FST_MIN [NUM_RULES] = '{FST_HIGH, FST_LOW, FST_SU_RS, FST_SU_STOP, FST_BUF};

  logic [CNT_W-1:0]     meas [NUM_RULES];
  logic [NUM_RULES-1:0] fire;
  logic [NUM_RULES-1:0] det;
  logic [CNT_W-1:0]     setup_cnt;

  // An SCL edge in the same cycle means SCL has had no high time at all
  assign setup_cnt = (scl_rise | scl_fall) ? '0 : scl_cnt;

  always_comb begin
    meas[RULE_HIGH]      = scl_cnt;
    meas[RULE_LOW]       = scl_cnt;
    meas[RULE_SU_RSTART] = setup_cnt;
    meas[RULE_SU_STOP]   = setup_cnt;
    meas[RULE_BUS_FREE]  = free_cnt;
    fire[RULE_HIGH]      = scl_fall & busy;
    fire[RULE_LOW]       = scl_rise & busy;
    fire[RULE_SU_RSTART] = start_c & busy;
    fire[RULE_SU_STOP]   = stop_c;
    fire[RULE_BUS_FREE]  = start_c & ~busy;
  end

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    int min_sel;
    assign min_sel = fast_mode ? FST_MIN[r] : STD_MIN[r];
    assign det[r]  = fire[r] && (int'(meas[r]) < min_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse  <= '0;
      viol_sticky <= '0;
    end else begin
      viol_pulse  <= det;
      viol_sticky <= (clear_sticky ? '0 : viol_sticky) | det;
    end
  end

  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse & ~viol_sticky) == '0); // R9
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_sticky |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky))); // R9
  AST_IDLE_NO_PHASE_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!viol_pulse[RULE_HIGH] && !viol_pulse[RULE_LOW])); // R10
  AST_BUSY_NO_FREE_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !viol_pulse[RULE_BUS_FREE]); // R6

endmodule

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor
  import i2c_mon_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int CNT_W       = 16,
  parameter int STD_HIGH    = ns_to_cyc(4000, CLK_MHZ),
  parameter int STD_LOW     = ns_to_cyc(4700, CLK_MHZ),
  parameter int STD_SU_RS   = ns_to_cyc(4700, CLK_MHZ),
  parameter int STD_SU_STOP = ns_to_cyc(4000, CLK_MHZ),
  parameter int STD_BUF     = ns_to_cyc(4700, CLK_MHZ),
  parameter int FST_HIGH    = ns_to_cyc(600, CLK_MHZ),
  parameter int FST_LOW     = ns_to_cyc(1300, CLK_MHZ),
  parameter int FST_SU_RS   = ns_to_cyc(600, CLK_MHZ),
  parameter int FST_SU_STOP = ns_to_cyc(600, CLK_MHZ),
  parameter int FST_BUF     = ns_to_cyc(1300, CLK_MHZ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 fast_mode,
  input  logic                 clear_sticky,
  output logic [NUM_RULES-1:0] viol_pulse,
  output logic [NUM_RULES-1:0] viol_sticky,
  output logic                 bus_busy
);

  logic             scl_rise, scl_fall, start_c, stop_c;
  logic [CNT_W-1:0] scl_cnt, free_cnt;

  i2c_mon_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .busy     (bus_busy)
  );

  // Length of the current SCL level
  i2c_mon_timer #(.CNT_W(CNT_W)) u_scl_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (scl_rise | scl_fall),
    .count   (scl_cnt)
  );

  // Time since the last stop
  i2c_mon_timer #(.CNT_W(CNT_W)) u_free_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (stop_c),
    .count   (free_cnt)
  );

  i2c_mon_rules #(
    .CNT_W(CNT_W),
    .STD_HIGH(STD_HIGH), .STD_LOW(STD_LOW), .STD_SU_RS(STD_SU_RS),
    .STD_SU_STOP(STD_SU_STOP), .STD_BUF(STD_BUF),
    .FST_HIGH(FST_HIGH), .FST_LOW(FST_LOW), .FST_SU_RS(FST_SU_RS),
    .FST_SU_STOP(FST_SU_STOP), .FST_BUF(FST_BUF)
  ) u_rules (
    .clk          (clk),
    .rst_n        (rst_n),
    .fast_mode    (fast_mode),
    .clear_sticky (clear_sticky),
    .scl_cnt      (scl_cnt),
    .free_cnt     (free_cnt),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_c      (start_c),
    .stop_c       (stop_c),
    .busy         (bus_busy),
    .viol_pulse   (viol_pulse),
    .viol_sticky  (viol_sticky)
  );

endmodule

// File: tb/sim_i2c_timing_monitor.sv
module sim_i2c_timing_monitor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       fast = 1'b0, clr = 1'b0;
  logic [4:0] pulse, sticky;
  logic       busy;

  int n_checks = 0, n_fail = 0;
  int now = 0;
  int t_scl = -1000000, t_stop = -1000000;
  bit busy_m = 0;
  int exp_cnt [5];
  int obs_cnt [5];
  logic [4:0] exp_sticky = '0;

  always #10 clk = ~clk; // 50 MHz

  i2c_timing_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .fast_mode(fast), .clear_sticky(clr),
    .viol_pulse(pulse), .viol_sticky(sticky), .bus_busy(busy)
  );

  always @(negedge clk) begin
    for (int r = 0; r < 5; r++) obs_cnt[r] += int'(pulse[r]);
  end

  // Minimums in 50 MHz cycles (R7)
  function automatic int min_cyc(input int r, input bit f);
    case (r)
      0: return f ? 30 : 200;
      1: return f ? 65 : 235;
      2: return f ? 30 : 235;
      3: return f ? 30 : 200;
      default: return f ? 65 : 235;
    endcase
  endfunction

  function automatic string rule_tag(input int r);
    case (r)
      0: return "R2 high";
      1: return "R3 low";
      2: return "R4 rstart-setup";
      3: return "R5 stop-setup";
      default: return "R6 bus-free";
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    now += n;
  endtask

  task automatic flag(input int r);
    exp_cnt[r]++;
    exp_sticky[r] = 1'b1;
  endtask

  // Apply new line levels now and update the timing model
  task automatic drive(input logic n_scl, input logic n_sda);
    int dur;
    if (n_scl != scl) begin
      dur = now - t_scl;
      if (busy_m) begin
        if (scl && dur < min_cyc(0, fast)) flag(0);
        if (!scl && dur < min_cyc(1, fast)) flag(1);
      end
      t_scl = now;
    end else if (n_sda != sda && scl) begin
      dur = now - t_scl;
      if (!n_sda) begin
        if (busy_m) begin
          if (dur < min_cyc(2, fast)) flag(2);
        end else if (now - t_stop < min_cyc(4, fast)) flag(4);
        busy_m = 1;
      end else begin
        if (dur < min_cyc(3, fast)) flag(3);
        busy_m = 0;
        t_stop = now;
      end
    end
    scl = n_scl;
    sda = n_sda;
  endtask

  task automatic compare_all(input string tag);
    for (int r = 0; r < 5; r++)
      check(obs_cnt[r] == exp_cnt[r], $sformatf("%s %s count", tag, rule_tag(r)),
            obs_cnt[r], exp_cnt[r]);
    check(sticky == exp_sticky, $sformatf("%s R9 sticky", tag), int'(sticky), int'(exp_sticky));
    check(busy == busy_m, $sformatf("%s R1 busy", tag), int'(busy), int'(busy_m));
  endtask

  function automatic int near(input int m);
    return m - 6 + int'($urandom_range(0, 12));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 5; r++) begin exp_cnt[r] = 0; obs_cnt[r] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 1'b0 && pulse == '0 && sticky == '0, "R11 in reset", int'({busy, pulse, sticky}), 0);
    rst_n = 1'b1;
    step(3);
    check(busy == 1'b0 && pulse == '0 && sticky == '0, "R11 after reset", int'({busy, pulse, sticky}), 0);

    // Directed: busy latency (R1) and stop-setup pulse latency (R8)
    drive(1'b1, 1'b0);
    step(1); check(busy == 1'b0, "R1 busy one edge after start", int'(busy), 0);
    step(1); check(busy == 1'b1, "R1 busy two edges after start", int'(busy), 1);
    step(48);
    drive(1'b0, 1'b0); step(300);
    drive(1'b1, 1'b0); step(10);
    drive(1'b1, 1'b1);
    step(1); check(pulse[3] == 1'b0, "R8 pulse not yet", int'(pulse[3]), 0);
    step(1); check(pulse[3] == 1'b1, "R8 pulse at two edges", int'(pulse[3]), 1);
    check(busy == 1'b0, "R1 idle after stop", int'(busy), 0);
    step(1); check(pulse[3] == 1'b0, "R8 pulse lasts one cycle", int'(pulse[3]), 0);
    compare_all("directed");

    // R9 sticky clear
    clr = 1'b1; step(1); clr = 1'b0; exp_sticky = '0;
    check(sticky == '0, "R9 clear", int'(sticky), 0);

    // R10 short SCL pulses while idle must not be checked
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b1); step(3);
      drive(1'b1, 1'b1); step(3);
    end
    step(3);
    compare_all("R10 idle toggles");
    step(300);

    // Random transactions, both minimum sets (R7)
    for (int tx = 0; tx < 24; tx++) begin
      int nseg;
      fast = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin
        clr = 1'b1; step(1); clr = 1'b0; exp_sticky = '0;
      end
      step(near(min_cyc(4, fast)) > 4 ? near(min_cyc(4, fast)) - 4 : 1);
      drive(1'b1, 1'b0);
      step(int'($urandom_range(2, 40)));
      nseg = int'($urandom_range(1, 2));
      for (int s = 0; s < nseg; s++) begin
        int nbits = int'($urandom_range(1, 3));
        for (int b = 0; b < nbits; b++) begin
          drive(1'b0, sda); step(2);
          drive(1'b0, 1'($urandom_range(0, 1)));
          step(near(min_cyc(1, fast)) - 2);
          drive(1'b1, sda);
          step(near(min_cyc(0, fast)));
        end
        if (s + 1 < nseg) begin
          // repeated start
          drive(1'b0, sda); step(2);
          drive(1'b0, 1'b1); step(near(min_cyc(1, fast)) - 2);
          drive(1'b1, 1'b1); step(near(min_cyc(2, fast)));
          drive(1'b1, 1'b0); step(int'($urandom_range(2, 40)));
        end
      end
      drive(1'b0, sda); step(2);
      drive(1'b0, 1'b0); step(near(min_cyc(1, fast)) - 2);
      drive(1'b1, 1'b0); step(near(min_cyc(3, fast)));
      drive(1'b1, 1'b1);
      step(3);
      compare_all($sformatf("tx%0d mode%0d R7", tx, fast));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule